// File: doc/BRIEF.md
# Light-Level Threshold Interrupt Unit

This unit watches a stream of light conversions. Each conversion arrives as a 4-bit exponent and a 20-bit mantissa. The unit compares every conversion with a programmable low limit and a programmable high limit. Each limit is held as a 4-bit exponent and a 12-bit result, and both sides of the comparison are expanded to a common linear scale first.

A limit violation raises the high or low flag only after a programmed run of consecutive violating conversions. Any conversion that does not violate a limit clears the run for that side. The unit also keeps two status bits: a conversion-ready bit and an overload bit.

The unit drives one interrupt pin. Its polarity is programmable, and its source is one of three events: the threshold flags, every conversion, or every fourth conversion. Software reaches the unit through single-cycle strobes that share one 16-bit write-data bus:
- a low-limit write
- a high-limit write
- a configuration write
- a status write
- a status read

Top module: `lux_thresh_irq`

## Requirements
- R1: After reset the high limit reads 0xBFFF and the low limit reads 0x0000. Both flags, the ready bit and the overload bit are 0. The configuration after reset is: run of one, latched, active-low pin, threshold source. With this configuration the pin idles at 1.
- R2: A conversion is taken as mantissa shifted left by its exponent. A limit is taken as its result shifted left by (exponent + 8). A conversion is "above" when it is strictly greater than the high limit, and "below" when it is strictly less than the low limit.
- R3: The run-length field selects how many consecutive violating conversions trip a flag: 0 selects 1, 1 selects 2, 2 selects 4 and 3 selects 8.
- R4: A conversion that is not above clears the high run, and a conversion that is not below clears the low run.
- R5: In latched mode, a tripped flag stays set until a status read. A trip in the same cycle as the read leaves the flag set.
- R6: In transparent mode, each conversion sets each flag to that conversion's trip result. A status read leaves the flags unchanged.
- R7: The ready bit sets on every conversion. It clears on a status read or on a status write with non-zero data, and a status write of zero leaves it unchanged. A conversion in the same cycle as a clear leaves the ready bit set.
- R8: The overload bit takes the overload input of the most recent conversion.
- R9: When the polarity bit is 1 the pin equals the active interrupt condition. When the polarity bit is 0 the pin is the inverse of that condition.
- R10: With source 0 the interrupt is active while either flag is set.
- R11: With source 1 the interrupt is active for the single cycle after each conversion.
- R12: With source 3 the interrupt is active for the single cycle after every fourth conversion, counted from reset.
- R13: Source 2 is never active.
- R14: Limit writes place the exponent in wdata[15:12] and the result in wdata[11:0]. A configuration write decodes wdata as follows: run length in [1:0], polarity in [2], latch enable in [3], source in [5:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | One-cycle strobe marking a finished conversion |
| meas_exp | input | 4 | Conversion exponent |
| meas_mant | input | 20 | Conversion mantissa |
| meas_ovf | input | 1 | Conversion exceeded full scale |
| wdata | input | 16 | Shared write data for all write strobes |
| thr_lo_wr | input | 1 | Write the low limit |
| thr_hi_wr | input | 1 | Write the high limit |
| cfg_wr | input | 1 | Write the configuration |
| stat_wr | input | 1 | Status write (non-zero clears ready) |
| stat_rd | input | 1 | Status read strobe |
| thr_lo_q | output | 16 | Low limit readback |
| thr_hi_q | output | 16 | High limit readback |
| flag_hi | output | 1 | High flag |
| flag_lo | output | 1 | Low flag |
| conv_rdy | output | 1 | Conversion ready bit |
| ovld | output | 1 | Overload bit |
| irq_pin | output | 1 | Interrupt pin |

## Verification
Every result is registered once. Flags, ready, overload, the per-conversion pulses and the limit readbacks all change on the clock edge that samples the strobe, and so do the configuration fields. The pin is a combinational function of those registers, so it is also due one edge after its cause.

The bench drives each strobe at a falling edge and updates its reference model at the following rising edge. It compares all outputs 2 ns after that rising edge, before any new input is applied. Back-to-back strobes therefore each get their own check.

// File: rtl/lux_irq_pkg.sv
package lux_irq_pkg;

    localparam int EXP_W      = 4;
    localparam int MANT_W     = 20;
    localparam int THR_RES_W  = 12;
    localparam int THR_SHIFT  = 8;
    localparam int MAX_RUN    = 8;
    localparam int QUAD_N     = 4;
    localparam int REG_W      = EXP_W + THR_RES_W;
    localparam int EXP_MAX    = (1 << EXP_W) - 1;
    localparam int MEAS_SPAN  = MANT_W + EXP_MAX;
    localparam int THR_SPAN   = THR_RES_W + THR_SHIFT + EXP_MAX;
    localparam int SCALED_W   = (MEAS_SPAN > THR_SPAN) ? MEAS_SPAN : THR_SPAN;
    localparam int RUN_W      = $clog2(MAX_RUN + 1);
    localparam int FSEL_W     = 2;

    typedef logic [SCALED_W-1:0] scaled_t;

    typedef struct packed {
        logic [EXP_W-1:0]     ex;
        logic [THR_RES_W-1:0] res;
    } thr_t;

    typedef enum logic [1:0] {
        SRC_ALERT = 2'd0,
        SRC_EACH  = 2'd1,
        SRC_NONE  = 2'd2,
        SRC_QUAD  = 2'd3
    } irq_src_e;

    typedef struct packed {
        irq_src_e          src;
        logic              latch;
        logic              pol;
        logic [FSEL_W-1:0] fsel;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam thr_t THR_HI_RST = '{ex: 4'hB, res: 12'hFFF};
    localparam thr_t THR_LO_RST = '{ex: 4'h0, res: 12'h000};
    localparam cfg_t CFG_RST    = '{src: SRC_ALERT, latch: 1'b1, pol: 1'b0, fsel: '0};

    function automatic scaled_t scale_meas(input logic [EXP_W-1:0] ex,
                                           input logic [MANT_W-1:0] mant);
        return scaled_t'(mant) << ex;
    endfunction

    function automatic scaled_t scale_thr(input thr_t t);
        return scaled_t'(t.res) << (int'(t.ex) + THR_SHIFT);
    endfunction

    function automatic logic [RUN_W-1:0] run_need(input logic [FSEL_W-1:0] fsel);
        return RUN_W'(1) << fsel;
    endfunction

endpackage

// File: rtl/lux_cmp.sv
module lux_cmp
    import lux_irq_pkg::*;
(
    input  logic [EXP_W-1:0]  meas_exp,
    input  logic [MANT_W-1:0] meas_mant,
    input  thr_t              thr_lo,
    input  thr_t              thr_hi,
    output logic              above,
    output logic              below
);
    scaled_t meas_lin;
    scaled_t lo_lin;
    scaled_t hi_lin;

    always_comb begin
        meas_lin = scale_meas(meas_exp, meas_mant);
        lo_lin   = scale_thr(thr_lo);
        hi_lin   = scale_thr(thr_hi);
        above    = meas_lin > hi_lin;
        below    = meas_lin < lo_lin;
    end
endmodule

// File: rtl/lux_run_ctr.sv
module lux_run_ctr #(
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             fault,
    input  logic [RUN_W-1:0] need,
    output logic             trip
);
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nxt;

    always_comb begin
        if (!fault)      run_nxt = '0;
        else if (&run_q) run_nxt = run_q;
        else             run_nxt = run_q + 1'b1;
        trip = evt && fault && (run_nxt >= need);
    end

    always_ff @(posedge clk) begin
        if (rst)      run_q <= '0;
        else if (evt) run_q <= run_nxt;
    end
endmodule

// File: rtl/lux_irq_gen.sv
module lux_irq_gen
    import lux_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     conv,
    input  irq_src_e src,
    input  logic     pol,
    input  logic     alert,
    output logic     pin
);
    localparam int QW = $clog2(QUAD_N);

    logic          each_q;
    logic          quad_q;
    logic [QW-1:0] conv_cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            each_q   <= 1'b0;
            quad_q   <= 1'b0;
            conv_cnt <= '0;
        end else begin
            each_q <= conv;
            quad_q <= conv && (conv_cnt == QW'(QUAD_N - 1));
            if (conv) conv_cnt <= conv_cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ALERT: active = alert;
            SRC_EACH:  active = each_q;
            SRC_QUAD:  active = quad_q;
            default:   active = 1'b0;
        endcase
        pin = pol ? active : ~active;
    end
endmodule

// File: rtl/lux_thresh_irq.sv
module lux_thresh_irq
    import lux_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_valid,
    input  logic [EXP_W-1:0]  meas_exp,
    input  logic [MANT_W-1:0] meas_mant,
    input  logic              meas_ovf,
    input  logic [REG_W-1:0]  wdata,
    input  logic              thr_lo_wr,
    input  logic              thr_hi_wr,
    input  logic              cfg_wr,
    input  logic              stat_wr,
    input  logic              stat_rd,
    output logic [REG_W-1:0]  thr_lo_q,
    output logic [REG_W-1:0]  thr_hi_q,
    output logic              flag_hi,
    output logic              flag_lo,
    output logic              conv_rdy,
    output logic              ovld,
    output logic              irq_pin
);
    localparam int N_DIR = 2;   // index 0: high side, index 1: low side

    thr_t             thr_lo_r;
    thr_t             thr_hi_r;
    cfg_t             cfg_q;
    logic [N_DIR-1:0] flags_q;
    logic [N_DIR-1:0] viol;
    logic [N_DIR-1:0] trip;
    logic             rdy_q;
    logic             ovl_q;
    logic [RUN_W-1:0] need;

    lux_cmp u_cmp (
        .meas_exp  (meas_exp),
        .meas_mant (meas_mant),
        .thr_lo    (thr_lo_r),
        .thr_hi    (thr_hi_r),
        .above     (viol[0]),
        .below     (viol[1])
    );

    assign need = run_need(cfg_q.fsel);

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        lux_run_ctr #(.RUN_W(RUN_W)) u_run (
            .clk   (clk),
            .rst   (rst),
            .evt   (meas_valid),
            .fault (viol[d]),
            .need  (need),
            .trip  (trip[d])
        );

        always_ff @(posedge clk) begin
            if (rst)
                flags_q[d] <= 1'b0;
            else if (cfg_q.latch)
                flags_q[d] <= (flags_q[d] & ~stat_rd) | trip[d];
            else if (meas_valid)
                flags_q[d] <= trip[d];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_lo_r <= THR_LO_RST;
            thr_hi_r <= THR_HI_RST;
            cfg_q    <= CFG_RST;
            rdy_q    <= 1'b0;
            ovl_q    <= 1'b0;
        end else begin
            if (thr_lo_wr) thr_lo_r <= thr_t'(wdata);
            if (thr_hi_wr) thr_hi_r <= thr_t'(wdata);
            if (cfg_wr)    cfg_q    <= cfg_t'(wdata[CFG_W-1:0]);
            if (meas_valid)
                rdy_q <= 1'b1;
            else if (stat_rd || (stat_wr && (wdata != '0)))
                rdy_q <= 1'b0;
            if (meas_valid) ovl_q <= meas_ovf;
        end
    end

    lux_irq_gen u_irq (
        .clk   (clk),
        .rst   (rst),
        .conv  (meas_valid),
        .src   (cfg_q.src),
        .pol   (cfg_q.pol),
        .alert (|flags_q),
        .pin   (irq_pin)
    );

    assign thr_lo_q = thr_lo_r;
    assign thr_hi_q = thr_hi_r;
    assign flag_hi  = flags_q[0];
    assign flag_lo  = flags_q[1];
    assign conv_rdy = rdy_q;
    assign ovld     = ovl_q;
endmodule

// File: rtl/lux_thresh_irq_chk.sv
module lux_thresh_irq_chk
    import lux_irq_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic meas_valid,
    input logic meas_ovf,
    input logic stat_rd,
    input logic cfg_wr,
    input cfg_t cfg_q,
    input logic flag_hi,
    input logic flag_lo,
    input logic conv_rdy,
    input logic ovld,
    input logic irq_pin
);
    // R7
    rdy_sets_chk: assert property (@(posedge clk) disable iff (rst)
        meas_valid |=> conv_rdy);

    // R8
    ovl_follows_chk: assert property (@(posedge clk) disable iff (rst)
        meas_valid |=> (ovld == $past(meas_ovf)));

    // R5
    latched_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.latch && flag_hi && !stat_rd) |=> flag_hi);

    // R6
    transp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.latch && !meas_valid) |=> ($stable(flag_hi) && $stable(flag_lo)));

    // R13
    src_none_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src == SRC_NONE) |-> (irq_pin == !cfg_q.pol));

    // R11
    each_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src == SRC_EACH && meas_valid && !cfg_wr) |=> (irq_pin == cfg_q.pol));
endmodule

bind lux_thresh_irq lux_thresh_irq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .meas_valid (meas_valid),
    .meas_ovf   (meas_ovf),
    .stat_rd    (stat_rd),
    .cfg_wr     (cfg_wr),
    .cfg_q      (cfg_q),
    .flag_hi    (flag_hi),
    .flag_lo    (flag_lo),
    .conv_rdy   (conv_rdy),
    .ovld       (ovld),
    .irq_pin    (irq_pin)
);

// File: tb/lux_thresh_irq_tb.sv
module lux_thresh_irq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        meas_valid, meas_ovf;
    logic [3:0]  meas_exp;
    logic [19:0] meas_mant;
    logic [15:0] wdata;
    logic        thr_lo_wr, thr_hi_wr, cfg_wr, stat_wr, stat_rd;
    logic [15:0] thr_lo_q, thr_hi_q;
    logic        flag_hi, flag_lo, conv_rdy, ovld, irq_pin;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [15:0] m_lo, m_hi;
    logic [1:0]  m_src, m_fsel;
    logic        m_latch, m_pol, m_fh, m_fl, m_rdy, m_ovl, m_p1, m_p4;
    int          m_hrun, m_lrun, m_cnt;

    always #10 clk = ~clk;

    lux_thresh_irq u_dut (
        .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_exp(meas_exp),
        .meas_mant(meas_mant), .meas_ovf(meas_ovf), .wdata(wdata),
        .thr_lo_wr(thr_lo_wr), .thr_hi_wr(thr_hi_wr), .cfg_wr(cfg_wr),
        .stat_wr(stat_wr), .stat_rd(stat_rd), .thr_lo_q(thr_lo_q),
        .thr_hi_q(thr_hi_q), .flag_hi(flag_hi), .flag_lo(flag_lo),
        .conv_rdy(conv_rdy), .ovld(ovld), .irq_pin(irq_pin)
    );

    function automatic longint lin_meas(input logic [3:0] e, input logic [19:0] m);
        return longint'(m) << e;
    endfunction

    function automatic longint lin_thr(input logic [15:0] t);
        return longint'(t[11:0]) << (int'(t[15:12]) + 8);
    endfunction

    function automatic logic exp_pin();
        logic act;
        case (m_src)
            2'd0:    act = m_fh | m_fl;
            2'd1:    act = m_p1;
            2'd3:    act = m_p4;
            default: act = 1'b0;
        endcase
        return m_pol ? act : !act;
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "flag_hi", flag_hi, m_fh);
        chk(tag, "flag_lo", flag_lo, m_fl);
        chk(tag, "conv_rdy", conv_rdy, m_rdy);
        chk(tag, "ovld", ovld, m_ovl);
        chk(tag, "irq_pin", irq_pin, exp_pin());
        chk(tag, "thr_lo_q", thr_lo_q, m_lo);
        chk(tag, "thr_hi_q", thr_hi_q, m_hi);
    endtask

    task automatic idle_inputs();
        meas_valid = 0; meas_exp = 0; meas_mant = 0; meas_ovf = 0; wdata = 0;
        thr_lo_wr = 0; thr_hi_wr = 0; cfg_wr = 0; stat_wr = 0; stat_rd = 0;
    endtask

    task automatic model_reset();
        m_lo = 16'h0000; m_hi = 16'hBFFF;
        m_src = 2'd0; m_latch = 1; m_pol = 0; m_fsel = 2'd0;
        m_fh = 0; m_fl = 0; m_rdy = 0; m_ovl = 0; m_p1 = 0; m_p4 = 0;
        m_hrun = 0; m_lrun = 0; m_cnt = 0;
    endtask

    task automatic cyc(input string tag, input logic v, input logic [3:0] e,
                       input logic [19:0] m, input logic o, input logic rd,
                       input logic sw, input logic cw, input logic lw,
                       input logic hw, input logic [15:0] d);
        longint mv;
        logic   ab, bl, th, tl;
        int     need;
        @(negedge clk);
        meas_valid = v; meas_exp = e; meas_mant = m; meas_ovf = o;
        stat_rd = rd; stat_wr = sw; cfg_wr = cw; thr_lo_wr = lw; thr_hi_wr = hw; wdata = d;
        @(posedge clk);
        mv   = lin_meas(e, m);
        ab   = mv > lin_thr(m_hi);
        bl   = mv < lin_thr(m_lo);
        need = 1 << m_fsel;
        th = 0; tl = 0;
        if (v) begin
            m_hrun = ab ? ((m_hrun < 15) ? m_hrun + 1 : 15) : 0;
            m_lrun = bl ? ((m_lrun < 15) ? m_lrun + 1 : 15) : 0;
            th = ab && (m_hrun >= need);
            tl = bl && (m_lrun >= need);
        end
        if (m_latch) begin
            m_fh = (m_fh && !rd) || th;
            m_fl = (m_fl && !rd) || tl;
        end else if (v) begin
            m_fh = th;
            m_fl = tl;
        end
        if (v) m_rdy = 1;
        else if (rd || (sw && d != 16'h0)) m_rdy = 0;
        if (v) m_ovl = o;
        m_p1 = v;
        m_p4 = v && (m_cnt == 3);
        if (v) m_cnt = (m_cnt + 1) % 4;
        if (cw) {m_src, m_latch, m_pol, m_fsel} = d[5:0];
        if (lw) m_lo = d;
        if (hw) m_hi = d;
        #2;
        chk_all(tag);
        idle_inputs();
    endtask

    // shorthand helpers
    task automatic conv(input string tag, input logic [3:0] e, input logic [19:0] m);
        cyc(tag, 1, e, m, 0, 0, 0, 0, 0, 0, 16'h0);
    endtask
    task automatic setcfg(input string tag, input logic [15:0] d);
        cyc(tag, 0, 0, 0, 0, 0, 0, 1, 0, 0, d);
    endtask
    task automatic rdstat(input string tag);
        cyc(tag, 0, 0, 0, 0, 1, 0, 0, 0, 0, 16'h0);
    endtask
    task automatic nop(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0);
    endtask

    localparam logic [19:0] ABOVE = 20'h10001;
    localparam logic [19:0] MID   = 20'h08000;
    localparam logic [19:0] BELOW = 20'h00FFF;

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        model_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk_all("R1");
        nop("R1");
        conv("R1", 4'hF, 20'hFFFFF);   // far above default high limit, trips with run of one
        rdstat("R1");

        // R14: limit field positions and configuration field positions
        cyc("R14", 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0100);  // high = 0x10000
        cyc("R14", 0, 0, 0, 0, 0, 0, 0, 1, 0, 16'h0010);  // low  = 0x1000
        setcfg("R14", 16'h0004);                            // polarity high
        setcfg("R14", 16'h0000);

        // R2: strict comparison on scaled values
        conv("R2", 4'h4, 20'h01000);    // equals high limit: not above
        conv("R2", 4'h0, ABOVE);
        conv("R2", 4'h0, 20'h01000);    // equals low limit: not below
        conv("R2", 4'h0, BELOW);
        conv("R2", 4'h3, 20'h00200);    // 0x1000 via exponent: in range
        conv("R2", 4'h5, 20'h00801);    // 0x10020: above

        // R3: run lengths (transparent mode)
        for (int f = 0; f < 4; f++) begin
            setcfg("R3", 16'(f));
            conv("R3", 0, MID);
            for (int k = 0; k < (1 << f) + 1; k++) conv("R3", 0, ABOVE);
            for (int k = 0; k < (1 << f) + 1; k++) conv("R3", 0, BELOW);
        end

        // R4: interruption clears the run
        setcfg("R4", 16'h0002);
        for (int k = 0; k < 3; k++) conv("R4", 0, ABOVE);
        conv("R4", 0, MID);
        for (int k = 0; k < 3; k++) conv("R4", 0, ABOVE);
        conv("R4", 0, ABOVE);
        for (int k = 0; k < 3; k++) conv("R4", 0, BELOW);
        conv("R4", 0, ABOVE);
        for (int k = 0; k < 4; k++) conv("R4", 0, BELOW);

        // R5: latched flags
        setcfg("R5", 16'h0008);
        conv("R5", 0, ABOVE);
        conv("R5", 0, MID);
        nop("R5");
        rdstat("R5");
        conv("R5", 0, BELOW);
        cyc("R5", 1, 0, ABOVE, 0, 1, 0, 0, 0, 0, 16'h0);   // read and new trip together
        rdstat("R5");

        // R6: transparent flags
        setcfg("R6", 16'h0000);
        conv("R6", 0, BELOW);
        rdstat("R6");
        nop("R6");
        conv("R6", 0, MID);

        // R7: ready bit
        conv("R7", 0, MID);
        cyc("R7", 0, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0000);
        cyc("R7", 0, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0100);
        conv("R7", 0, MID);
        rdstat("R7");
        conv("R7", 0, MID);
        cyc("R7", 1, 0, MID, 0, 1, 0, 0, 0, 0, 16'h0);

        // R8: overload
        cyc("R8", 1, 0, MID, 1, 0, 0, 0, 0, 0, 16'h0);
        nop("R8");
        cyc("R8", 1, 0, MID, 0, 0, 0, 0, 0, 0, 16'h0);

        // R9 / R10: polarity and threshold source
        setcfg("R10", 16'h000C);
        conv("R10", 0, BELOW);
        nop("R10");
        setcfg("R9", 16'h0008);
        nop("R9");
        rdstat("R9");

        // R11: pulse after each conversion
        setcfg("R11", 16'h0014);
        conv("R11", 0, MID);
        nop("R11");
        conv("R11", 0, MID);
        conv("R11", 0, MID);
        nop("R11");

        // R12: pulse after every fourth conversion
        setcfg("R12", 16'h0034);
        for (int k = 0; k < 9; k++) begin
            conv("R12", 0, MID);
            nop("R12");
        end

        // R13: invalid source
        setcfg("R13", 16'h0024);
        conv("R13", 0, BELOW);
        conv("R13", 0, MID);
        setcfg("R13", 16'h0020);
        conv("R13", 0, ABOVE);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] d;
            int          r;
            r = $urandom % 100;
            d = 16'($urandom);
            d[15] = 1'b0;                // keep limit exponents within 0..7
            if (r < 2)
                cyc("R2", 0, 0, 0, 0, 0, 0, 0, 1, 0, d);
            else if (r < 4)
                cyc("R2", 0, 0, 0, 0, 0, 0, 0, 0, 1, d);
            else if (r < 7)
                cyc("R14", 0, 0, 0, 0, 0, 0, 1, 0, 0, {10'h0, d[5:0]});
            else
                cyc("R2", ($urandom % 100) < 60, 4'($urandom % 8), 20'($urandom),
                    1'($urandom), ($urandom % 100) < 15, ($urandom % 100) < 5,
                    0, 0, 0, {14'h0, 2'($urandom)});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule